// File: doc/BRIEF.md
# Calibrated Thermal Code Converter

This block converts between the 12-bit output code of an on-die thermal sensor and a temperature in millidegrees Celsius. Two calibration codes are used. The cold code is the sensor reading at −41 °C and the hot code is the reading at +126 °C. Between them the block interpolates linearly. In forward mode it turns a sensor code into a signed millidegree value. In inverse mode it turns a millidegree threshold into the 12-bit code that a hardware comparator would need.

Each conversion begins with a one-cycle `start` pulse. The block latches the direction, the operands and both calibration codes on that edge. It then runs a fixed-length restoring division and signals completion with a one-cycle `done` pulse. The result and the error flag hold their values until the next completion.

Before any arithmetic, the calibration pair is validated. A bad pair ends the conversion at once with the error flag set and a result of zero.

Top module: `thermo_code_conv`

## Requirements
- R1: With `inv_mode`=0 and valid calibration, `result` = trunc(167000·(a−b)/(c−b)) − 41000. Here a = `sens_code`, b = `cal_cold` and c = `cal_hot`, all unsigned 12-bit. The quotient is truncated toward zero, and b may be greater than c.
- R2: A forward result is clamped to the range −41000 to 126000 inclusive.
- R3: With `inv_mode`=1 and valid calibration, `result` = trunc((T+41000)·(c−b)/167000) + b. Here T = `thresh_mdeg`, a signed 32-bit value, and the quotient is truncated toward zero.
- R4: An inverse result is clamped to the range 0 to 4095 inclusive.
- R5: The calibration is invalid if b or c is 0, if b or c is 4095, or if b equals c. In that case `done` pulses on the edge after the accepting edge, with `cal_err`=1 and `result`=0. A valid conversion ends with `cal_err`=0.
- R6: A valid conversion raises `done` on the 65th rising edge after the edge that accepted `start`. `busy` is high from the edge after acceptance up to and including that 65th edge, and low in the `done` cycle.
- R7: `done` is high for exactly one cycle. `result` and `cal_err` change only on an edge that also raises `done`.
- R8: While `busy` is high, a `start` pulse and any change to the operand, direction or calibration inputs have no effect on the result or on its timing.
- R9: A `start` presented in the cycle in which `done` is high is accepted.
- R10: While reset is low, and after its release until the first completion, `done`, `busy` and `cal_err` are 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a conversion (accepted when not busy) |
| inv_mode | input | 1 | 0: code to millidegrees, 1: millidegrees to code |
| sens_code | input | 12 | Sensor code for forward mode |
| thresh_mdeg | input | 32 | Signed millidegree threshold for inverse mode |
| cal_cold | input | 12 | Calibration code at −41 °C |
| cal_hot | input | 12 | Calibration code at +126 °C |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| cal_err | output | 1 | Last conversion hit invalid calibration |
| result | output | 32 | Signed millidegrees, or a code zero-extended |

## Verification
Several properties are checked by assertions on every cycle. These are the one-cycle `done` pulse, the holding of `result` and `cal_err` between completions, and the zero result on a calibration error. The assertions also check that each result lies inside the clamp window for its latched direction, and that completion arrives after exactly 65 edges on the valid path and 1 edge on the error path. The latency is measured from the last accepted start, so a start that arrives while busy and restarts the block would show up as a latency error. Only the bench scenarios can show the actual quotient values. This covers truncation toward zero with a negative numerator or a reversed calibration pair, clamping at the exact limits, and the fact that operands changed after acceptance leave the result unchanged.

// File: rtl/tcv_pkg.sv
package tcv_pkg;
  localparam int CODE_W = 12;
  localparam int PROD_W = 64;
  localparam int RES_W  = 32;

  typedef logic [CODE_W-1:0]        code_t;
  typedef logic [PROD_W-1:0]        mag_t;
  typedef logic signed [PROD_W-1:0] wide_t;

  localparam code_t CODE_MAX  = '1;
  localparam wide_t TEMP_LO   = wide_t'(-41000);
  localparam wide_t TEMP_HI   = wide_t'(126000);
  localparam wide_t TEMP_SPAN = TEMP_HI - TEMP_LO;

  typedef enum logic [1:0] {ST_IDLE, ST_DIV, ST_BAD} state_t;

  typedef struct packed {
    mag_t  num;
    mag_t  den;
    logic  neg;
    wide_t off;
  } div_job_t;

  function automatic logic cal_valid(code_t b, code_t c);
    return (b != '0) && (c != '0) && (b != CODE_MAX) && (c != CODE_MAX) && (b != c);
  endfunction

  function automatic wide_t code_diff(code_t x, code_t y);
    return wide_t'({1'b0, x}) - wide_t'({1'b0, y});
  endfunction

  function automatic mag_t mag_of(wide_t v);
    return v[PROD_W-1] ? mag_t'(-v) : mag_t'(v);
  endfunction

  // Numerator/denominator magnitudes plus quotient sign and post-offset.
  function automatic div_job_t build_job(logic inv, code_t a,
                                         logic signed [RES_W-1:0] t,
                                         code_t b, code_t c);
    div_job_t j;
    wide_t n;
    wide_t d;
    if (!inv) begin
      n     = TEMP_SPAN * code_diff(a, b);
      d     = code_diff(c, b);
      j.off = TEMP_LO;
    end else begin
      n     = (wide_t'(t) - TEMP_LO) * code_diff(c, b);
      d     = TEMP_SPAN;
      j.off = wide_t'({1'b0, b});
    end
    j.num = mag_of(n);
    j.den = mag_of(d);
    j.neg = n[PROD_W-1] ^ d[PROD_W-1];
    return j;
  endfunction

  // Apply sign, offset and the direction-dependent clamp window.
  function automatic logic signed [RES_W-1:0] finish_val(mag_t q, logic neg,
                                                         wide_t off, logic inv);
    wide_t s;
    wide_t lo;
    wide_t hi;
    s  = (neg ? -wide_t'(q) : wide_t'(q)) + off;
    lo = inv ? wide_t'(0) : TEMP_LO;
    hi = inv ? wide_t'({1'b0, CODE_MAX}) : TEMP_HI;
    if (s < lo)      s = lo;
    else if (s > hi) s = hi;
    return RES_W'(s);
  endfunction
endpackage

// File: rtl/tcv_front.sv
module tcv_front
  import tcv_pkg::*;
(
  input  logic                    inv,
  input  code_t                   code,
  input  logic signed [RES_W-1:0] thresh,
  input  code_t                   cold,
  input  code_t                   hot,
  output div_job_t                job,
  output logic                    cal_ok
);
  always_comb begin
    job    = build_job(inv, code, thresh, cold, hot);
    cal_ok = cal_valid(cold, hot);
  end
endmodule

// File: rtl/tcv_divider.sv
module tcv_divider #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic [W-1:0] quo,
  output logic         fin
);
  localparam int CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic [W-1:0]     rem;
  logic [W-1:0]     qr;
  logic [W-1:0]     den_q;
  logic [CNT_W-1:0] cnt;
  logic             run;
  logic [W:0]       sh;
  logic [W:0]       diff;
  logic             fits;

  always_comb begin
    sh   = {rem, qr[W-1]};
    diff = sh - {1'b0, den_q};
    fits = ~diff[W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem   <= '0;
      qr    <= '0;
      den_q <= '0;
      cnt   <= '0;
      run   <= 1'b0;
      fin   <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        rem   <= '0;
        qr    <= num;
        den_q <= den;
        cnt   <= '0;
        run   <= 1'b1;
      end else if (run) begin
        rem <= fits ? diff[W-1:0] : sh[W-1:0];
        qr  <= {qr[W-2:0], fits};
        cnt <= cnt + 1'b1;
        if (cnt == LAST) begin
          run <= 1'b0;
          fin <= 1'b1;
        end
      end
    end
  end

  assign quo = qr;
endmodule

// File: rtl/tcv_back.sv
module tcv_back
  import tcv_pkg::*;
(
  input  mag_t                    q,
  input  logic                    neg,
  input  wide_t                   off,
  input  logic                    inv,
  output logic signed [RES_W-1:0] val
);
  always_comb val = finish_val(q, neg, off, inv);
endmodule

// File: rtl/thermo_code_conv.sv
module thermo_code_conv
  import tcv_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    inv_mode,
  input  logic [CODE_W-1:0]       sens_code,
  input  logic signed [RES_W-1:0] thresh_mdeg,
  input  logic [CODE_W-1:0]       cal_cold,
  input  logic [CODE_W-1:0]       cal_hot,
  output logic                    busy,
  output logic                    done,
  output logic                    cal_err,
  output logic signed [RES_W-1:0] result
);
  state_t                  st;
  div_job_t                job;
  logic                    cal_ok;
  logic                    accept;
  logic                    div_go;
  logic                    div_fin;
  mag_t                    quo;
  logic                    mode_q;
  logic                    neg_q;
  wide_t                   off_q;
  logic signed [RES_W-1:0] fin_val;

  tcv_front u_front (
    .inv(inv_mode), .code(sens_code), .thresh(thresh_mdeg),
    .cold(cal_cold), .hot(cal_hot), .job(job), .cal_ok(cal_ok)
  );

  assign busy   = (st != ST_IDLE);
  assign accept = start && (st == ST_IDLE);
  assign div_go = accept && cal_ok;

  tcv_divider #(.W(PROD_W)) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go),
    .num(job.num), .den(job.den), .quo(quo), .fin(div_fin)
  );

  tcv_back u_back (
    .q(quo), .neg(neg_q), .off(off_q), .inv(mode_q), .val(fin_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      done    <= 1'b0;
      cal_err <= 1'b0;
      result  <= '0;
      mode_q  <= 1'b0;
      neg_q   <= 1'b0;
      off_q   <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (accept) begin
          mode_q <= inv_mode;
          neg_q  <= job.neg;
          off_q  <= job.off;
          st     <= cal_ok ? ST_DIV : ST_BAD;
        end
        ST_DIV: if (div_fin) begin
          result  <= fin_val;
          cal_err <= 1'b0;
          done    <= 1'b1;
          st      <= ST_IDLE;
        end
        ST_BAD: begin
          result  <= '0;
          cal_err <= 1'b1;
          done    <= 1'b1;
          st      <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tcv_check.sv
module tcv_check
  import tcv_pkg::*;
(
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start,
  input logic                    busy,
  input logic                    done,
  input logic                    cal_err,
  input logic signed [RES_W-1:0] result,
  input logic                    mode_q,
  input logic                    div_fin
);
  localparam int CW = $clog2(PROD_W + 4);
  localparam logic [CW-1:0] RUN_EDGES = CW'(PROD_W + 1);

  logic [CW-1:0] since;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since <= '1;
    else if (start && !busy)    since <= '0;
    else if (since != '1)       since <= since + 1'b1;
  end

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(result) && $stable(cal_err)));
  a_r5_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cal_err) |-> (result == '0));
  a_r5_err_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cal_err) |-> (since == CW'(1)));
  a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cal_err) |-> (since == RUN_EDGES));
  a_r6_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r8_fin_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    div_fin |-> busy);
  a_r2_fwd_window: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cal_err && !mode_q) |-> (result >= -41000 && result <= 126000));
  a_r4_inv_window: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cal_err && mode_q) |-> (result >= 0 && result <= 4095));
endmodule

bind thermo_code_conv tcv_check u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .cal_err(cal_err), .result(result), .mode_q(mode_q), .div_fin(div_fin)
);

// File: tb/sim_thermo_code_conv.sv
module sim_thermo_code_conv;
  localparam int CLK_PERIOD = 10;
  localparam int RUN_EDGES  = 65;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               start = 1'b0;
  logic               inv_mode = 1'b0;
  logic [11:0]        sens_code = '0;
  logic signed [31:0] thresh_mdeg = '0;
  logic [11:0]        cal_cold = '0;
  logic [11:0]        cal_hot = '0;
  logic               busy, done, cal_err;
  logic signed [31:0] result;

  int checks = 0;
  int errors = 0;
  bit armed = 0;
  bit finished = 0;
  string drv_tag = "R10";

  // reference model state
  bit     m_busy = 0;
  bit     m_err = 0;
  longint m_val = 0;
  string  m_tag = "R10";
  longint cyc = 0;
  longint m_due = 0;
  bit     e_done = 0;
  bit     e_err = 0;
  longint e_res = 0;
  string  e_tag = "R10";
  int     model_dones = 0;
  int     dut_dones = 0;

  thermo_code_conv u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .inv_mode(inv_mode),
    .sens_code(sens_code), .thresh_mdeg(thresh_mdeg), .cal_cold(cal_cold),
    .cal_hot(cal_hot), .busy(busy), .done(done), .cal_err(cal_err),
    .result(result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic longint ref_fwd(int a, int b, int c);
    longint q;
    q = (longint'(167000) * longint'(a - b)) / longint'(c - b);
    q = q - 41000;
    if (q < -41000) q = -41000;
    if (q > 126000) q = 126000;
    return q;
  endfunction

  function automatic longint ref_inv(int t, int b, int c);
    longint q;
    q = ((longint'(t) + 41000) * longint'(c - b)) / 167000;
    q = q + b;
    if (q < 0) q = 0;
    if (q > 4095) q = 4095;
    return q;
  endfunction

  function automatic bit ref_ok(int b, int c);
    return !(b == 0 || c == 0 || b == 4095 || c == 4095 || b == c);
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // cycle model
  always @(posedge clk) begin : model
    bit was_busy;
    int a, b, c, t;
    if (!rst_n) begin
      m_busy = 0; e_done = 0; e_err = 0; e_res = 0; cyc = 0;
    end else begin
      was_busy = m_busy;
      cyc++;
      e_done = 0;
      if (m_busy && cyc == m_due) begin
        e_done = 1; e_res = m_val; e_err = m_err; e_tag = m_tag;
        m_busy = 0; model_dones++;
      end
      if (start && !was_busy) begin
        a = int'(sens_code); b = int'(cal_cold); c = int'(cal_hot);
        t = int'(thresh_mdeg);
        m_tag = drv_tag;
        if (!ref_ok(b, c)) begin
          m_err = 1; m_val = 0; m_due = cyc + 1;
        end else begin
          m_err = 0;
          m_val = inv_mode ? ref_inv(t, b, c) : ref_fwd(a, b, c);
          m_due = cyc + RUN_EDGES;
        end
        m_busy = 1;
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    string tg;
    if (armed && !finished) begin
      tg = !rst_n ? "R10" : (e_done ? e_tag : "R7 hold");
      chk(done === e_done, "R5/R6 done timing", longint'(done), longint'(e_done));
      chk(busy === m_busy, "R6/R9 busy", longint'(busy), longint'(m_busy));
      chk(cal_err === e_err, tg, longint'(cal_err), longint'(e_err));
      chk(result === 32'(e_res), tg, longint'(result), e_res);
      if (done === 1'b1) dut_dones++;
    end
  end

  // operands are scrambled after the start pulse: R8 latching
  task automatic op(string tag, bit inv, int a, int t, int b, int c);
    while (m_busy) @(negedge clk);
    drv_tag = tag; inv_mode = inv; sens_code = a[11:0]; thresh_mdeg = t;
    cal_cold = b[11:0]; cal_hot = c[11:0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    sens_code = ~sens_code; cal_cold = ~cal_cold; cal_hot = cal_hot ^ 12'h5A5;
    thresh_mdeg = ~thresh_mdeg; inv_mode = ~inv_mode;
  endtask

  initial begin
    @(posedge clk);
    armed = 1;
    repeat (3) @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0 && result === 32'sd0, "R10 reset",
        longint'(result), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && cal_err === 1'b0, "R10 after release", longint'(busy), 0);

    // R1 forward, ordinary and reversed calibration (truncation toward zero)
    op("R1", 0, 2000, 0, 1000, 3000);
    op("R1", 0, 2999, 0, 3000, 1000);
    op("R1", 0, 1010, 0, 1000, 3001);
    for (int i = 0; i < 16; i++)
      op("R1", 0, (i * 173 + 905) % 2200 + 800, 0, 800 + i * 7, 2900 - i * 11);
    // R2 clamps
    op("R2", 0, 4000, 0, 1000, 2000);
    op("R2", 0, 3001, 0, 3000, 1000);
    op("R2", 0, 5, 0, 1000, 3000);
    op("R2", 0, 4095, 0, 1, 4094);
    // R3 inverse, including negative numerator truncation
    op("R3", 1, 0, 25000, 1000, 3000);
    op("R3", 1, 0, -41001, 1000, 3000);
    op("R3", 1, 0, -41100, 1000, 3000);
    op("R3", 1, 0, 60000, 3000, 1000);
    for (int i = 0; i < 12; i++)
      op("R3", 1, 0, -40000 + i * 13777, 700 + i * 5, 3100 - i * 9);
    // R4 clamps
    op("R4", 1, 0, 500000, 1000, 3000);
    op("R4", 1, 0, -2000000, 100, 3000);
    op("R4", 1, 0, 2147483647, 10, 4094);
    op("R4", 1, 0, 2147483647, 4094, 10);
    op("R4", 1, 0, -2147483647 - 1, 10, 4094);
    // R5 invalid calibration in both directions
    op("R5", 0, 2000, 0, 0, 2000);
    op("R5", 1, 0, 1000, 2000, 0);
    op("R5", 0, 2000, 0, 4095, 1000);
    op("R5", 1, 0, 1000, 1000, 4095);
    op("R5", 0, 2000, 0, 1500, 1500);
    op("R1", 0, 2000, 0, 1000, 3000);
    // R8 start pulses while busy, with different operands
    op("R8", 0, 3000, 0, 1000, 3000);
    repeat (10) @(negedge clk);
    drv_tag = "R8 ignored"; inv_mode = 1; cal_cold = 0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (40) @(negedge clk);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    // R9 back-to-back starts land in the done cycle
    op("R9", 1, 0, 0, 1000, 3000);
    op("R9", 0, 1500, 0, 1000, 3000);
    while (m_busy) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(dut_dones == model_dones, "R8 done count", dut_dones, model_dones);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL R6 watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule